// File: doc/BRIEF.md
# SECDED-Protected Synchronous Memory Controller

This block is a synchronous word memory, 32 data bits wide, that keeps seven check bits beside every stored word. Each write encodes the host word into a 39-bit single-error-correcting, double-error-detecting codeword. Each read runs the stored codeword through a syndrome decoder inline. A single flipped bit, whether in the data or in a check bit, is repaired in the word handed back to the host. A word with two flipped bits is returned uncorrected, and an error flag goes high with it. The repaired word is not written back into the array.

The host side uses a select pair: `sel_n` is active low and `sel` is active high. It also has a write strobe, an output enable and a split data bus. The split bus is an input word, an output word and a drive-enable bit that a pad ring would turn into a tristate. A configuration input switches off correction and flagging, so that raw stored data reaches the host. A fault-injection mask is applied to the codeword at write time, which lets a system plant known errors. The depth is set by `ADDR_W`. The intended full size is 19 address bits, and the default is kept small for elaboration.

Top module: `secded_sram_ctrl`

## Requirements
- R1: A rising clock edge with `sel_n`=0, `sel`=1 and `we_n`=0 stores `dq_in` at `addr`, whatever the value of `oe_n`.
- R2: A rising edge with `sel_n`=0, `sel`=1, `we_n`=1 and `oe_n`=0 is a read. After that edge, `dq_oe`=1 and `dq_out` holds the word at `addr`.
- R3: After an edge where `sel_n`=1, `sel`=0, `oe_n`=1 or a write is taking place, `dq_oe` is 0 and `dq_out` is 0.
- R4: A read of a word whose stored codeword differs from the encoded value in exactly two bit positions sets `err_flag`=1 for that read. `err_flag` is 0 whenever `dq_oe` is 0.
- R5: A read of a word with exactly one flipped codeword bit, in any of the 39 positions, returns the originally written data with `err_flag`=0.
- R6: When `cfg_bypass`=1 during a read, `dq_out` carries the stored data bits (codeword bits 31:0) without correction, and `err_flag`=0. When it is 0, correction applies.
- R7: On a write, `flip_mask` is XORed into the stored 39-bit codeword. Bits 31:0 are data bits 31:0, and bits 38:32 are the seven check bits.
- R8: While `rst_n`=0, `dq_oe`, `dq_out` and `err_flag` are 0 after each edge.
- R9: A corrected read leaves the array unchanged: a later bypass read of the same word still shows the flipped data bit.
- R10: A write strobe with the block deselected (`sel`=0 or `sel_n`=1) leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_in | input | 32 | Write data |
| flip_mask | input | 39 | Codeword bits inverted on write |
| cfg_bypass | input | 1 | 1 disables correction and flagging |
| dq_out | output | 32 | Read data, 0 when not driven |
| dq_oe | output | 1 | Data bus drive enable |
| err_flag | output | 1 | Uncorrectable word on this read |

## Verification
On every cycle, the assertions check the bus truth table: reads raise the drive enable one cycle later, and any other combination lowers it. They also check that the error flag and output data stay quiet while the bus is not driven, and that bypass reads never flag. In addition, they confirm that the decoder never reports a single and an uncorrectable error at once, and that the array is written only under the port write condition. Only the bench scenarios can show data values. These include correction at each of the 39 bit positions, flagging of double errors, raw data under bypass, the absence of write-back and the rejection of deselected writes.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int CODE_W = DATA_W + CHK_W;

  typedef logic [CHK_W-1:0] col_t;
  typedef col_t col_arr_t [DATA_W];

  // Data columns: the first DATA_W weight-3 values in ascending order.
  function automatic col_arr_t build_cols();
    col_arr_t cols;
    int k;
    k = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      logic [CHK_W-1:0] v7;
      v7 = v[CHK_W-1:0];
      if ($countones(v7) == 3 && k < DATA_W) begin
        cols[k] = v7;
        k++;
      end
    end
    return cols;
  endfunction

  localparam col_arr_t HCOLS = build_cols();

  function automatic logic [CHK_W-1:0] calc_chk(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) c = c ^ HCOLS[i];
    return c;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  assign code = {calc_chk(data), data};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] fixed,
  output logic              single,
  output logic              multi
);
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] hit;

  assign syn = calc_chk(code[DATA_W-1:0]) ^ code[CODE_W-1:DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    assign hit[i] = (syn == HCOLS[i]);
  end

  assign single = (|hit) | $onehot(syn);
  assign multi  = (syn != '0) && !single;
  assign fixed  = code[DATA_W-1:0] ^ hit;
endmodule

// File: rtl/bus_decode.sv
module bus_decode (
  input  logic sel_n,
  input  logic sel,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_go,
  output logic rd_go
);
  logic chosen;
  assign chosen = !sel_n && sel;
  assign wr_go  = chosen && !we_n;
  assign rd_go  = chosen && we_n && !oe_n;
endmodule

// File: rtl/secded_sram_ctrl.sv
module secded_sram_ctrl
  import secded_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       dq_in,
  input  logic [38:0]       flip_mask,
  input  logic              cfg_bypass,
  output logic [31:0]       dq_out,
  output logic              dq_oe,
  output logic              err_flag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              arr_we;
  logic              rd_go;
  logic [CODE_W-1:0] enc_code;
  logic [CODE_W-1:0] rd_code;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single;
  logic              dec_double;
  logic [DATA_W-1:0] host_word;

  logic [CODE_W-1:0] mem [DEPTH];

  bus_decode u_bus (
    .sel_n (sel_n),
    .sel   (sel),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .wr_go (arr_we),
    .rd_go (rd_go)
  );

  secded_enc u_enc (
    .data (dq_in),
    .code (enc_code)
  );

  always_ff @(posedge clk) begin
    if (arr_we) mem[addr] <= enc_code ^ flip_mask;
  end

  assign rd_code = mem[addr];

  secded_dec u_dec (
    .code   (rd_code),
    .fixed  (dec_data),
    .single (dec_single),
    .multi  (dec_double)
  );

  assign host_word = cfg_bypass ? rd_code[DATA_W-1:0] : dec_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      err_flag <= 1'b0;
    end else begin
      dq_oe    <= rd_go;
      dq_out   <= rd_go ? host_word : '0;
      err_flag <= rd_go && !cfg_bypass && dec_double;
    end
  end
endmodule

// File: rtl/secded_sram_chk.sv
module secded_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_n,
  input logic        sel,
  input logic        we_n,
  input logic        oe_n,
  input logic        cfg_bypass,
  input logic [31:0] dq_out,
  input logic        dq_oe,
  input logic        err_flag,
  input logic        arr_we,
  input logic        dec_single,
  input logic        dec_double
);
  logic port_rd;
  logic port_wr;
  assign port_rd = !sel_n && sel && we_n && !oe_n;
  assign port_wr = !sel_n && sel && !we_n;

  // R2
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> dq_oe);

  // R3
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_rd |=> !dq_oe);

  // R3
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 32'h0);

  // R4
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> !err_flag);

  // R6
  bypass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && cfg_bypass) |=> !err_flag);

  // R5
  dec_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_single, dec_double}));

  // R9
  no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> port_wr);
endmodule

bind secded_sram_ctrl secded_sram_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n      (sel_n),
  .sel        (sel),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .cfg_bypass (cfg_bypass),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .err_flag   (err_flag),
  .arr_we     (arr_we),
  .dec_single (dec_single),
  .dec_double (dec_double)
);

// File: tb/test_secded_sram_ctrl.sv
module test_secded_sram_ctrl;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1, sel = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0]   dq_in = '0;
  logic [38:0]   flip_mask = '0;
  logic          cfg_bypass = 1'b0;
  logic [31:0]   dq_out;
  logic          dq_oe, err_flag;

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R8";

  always #2.5 clk = ~clk;

  secded_sram_ctrl #(.ADDR_W(AW)) i_secded_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .flip_mask(flip_mask),
    .cfg_bypass(cfg_bypass), .dq_out(dq_out), .dq_oe(dq_oe), .err_flag(err_flag)
  );

  // Behavioural reference: written word plus injected flips per address.
  logic [31:0] m_data [NW];
  logic [38:0] m_flip [NW];
  logic        e_oe, e_err;
  logic [31:0] e_out;
  string       e_tag;

  initial begin
    e_oe = 0; e_err = 0; e_out = 0; e_tag = "R8";
  end

  always @(posedge clk) begin
    bit rd, wr;
    int nflip;
    logic [31:0] raw;
    e_tag = tag;
    rd = !sel_n && sel && we_n && !oe_n;
    wr = !sel_n && sel && !we_n;
    if (!rst_n) begin
      e_oe = 0; e_out = 0; e_err = 0;
    end else begin
      e_oe = rd; e_out = 0; e_err = 0;
      if (rd) begin
        nflip = $countones(m_flip[addr]);
        raw   = m_data[addr] ^ m_flip[addr][31:0];
        if (cfg_bypass)      e_out = raw;
        else if (nflip <= 1) e_out = m_data[addr];
        else begin e_out = raw; e_err = 1; end
      end
    end
    if (wr) begin
      m_data[addr] = dq_in;
      m_flip[addr] = flip_mask;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (dq_oe !== e_oe || dq_out !== e_out || err_flag !== e_err) begin
        fails++;
        $display("FAIL %s: oe/out/err actual %0b/%h/%0b expected %0b/%h/%0b",
                 e_tag, dq_oe, dq_out, err_flag, e_oe, e_out, e_err);
      end
    end
  end

  task automatic cyc(input logic s_n, input logic s, input logic w_n,
                     input logic o_n, input int a, input logic [31:0] d,
                     input logic [38:0] f, input logic byp);
    sel_n = s_n; sel = s; we_n = w_n; oe_n = o_n;
    addr = AW'(a); dq_in = d; flip_mask = f; cfg_bypass = byp;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [38:0] f,
                    input logic o_n);
    cyc(0, 1, 0, o_n, a, d, f, 0);
  endtask

  task automatic rd(input int a, input logic byp);
    cyc(0, 1, 1, 0, a, 32'h0, 39'h0, byp);
  endtask

  task automatic idle();
    cyc(1, 0, 1, 1, 0, 32'h0, 39'h0, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    tag = "R8";
    cyc(0, 1, 1, 0, 0, 32'h0, 39'h0, 0);
    cyc(0, 1, 1, 0, 1, 32'h0, 39'h0, 0);
    rst_n = 1;
    idle();

    tag = "R1";
    for (int i = 0; i < NW; i++) wr(i, 32'h9E37_79B9 * (i + 1), 39'h0, i[0]);

    tag = "R2";
    for (int i = 0; i < 8; i++) rd((i * 7) % NW, 0);
    rd(NW - 1, 0);
    rd(0, 0);

    tag = "R3";
    cyc(1, 1, 1, 0, 3, 0, 0, 0);
    cyc(0, 0, 1, 0, 3, 0, 0, 0);
    cyc(0, 1, 1, 1, 3, 0, 0, 0);
    rd(3, 0);
    wr(5, 32'h1234_5678, 39'h0, 0);
    rd(5, 0);

    tag = "R10";
    cyc(0, 0, 0, 0, 5, 32'hDEAD_BEEF, 39'h0, 0);
    cyc(1, 1, 0, 1, 5, 32'hCAFE_F00D, 39'h0, 0);
    rd(5, 0);

    tag = "R5";
    for (int k = 0; k < 39; k++) wr(k, 32'hA5C3_0F96 ^ (32'h0101_0101 * k), 39'h1 << k, 0);
    for (int k = 0; k < 39; k++) rd(k, 0);

    tag = "R7";
    for (int k = 0; k < 39; k++) rd(k, 1);

    tag = "R4";
    wr(40, 32'hFFFF_0000, 39'h3, 0);
    wr(41, 32'h0F0F_0F0F, (39'h1 << 31) | (39'h1 << 32), 0);
    wr(42, 32'h7777_7777, (39'h1 << 37) | (39'h1 << 38), 0);
    wr(43, 32'h0000_0001, (39'h1 << 5) | (39'h1 << 20), 0);
    for (int a = 40; a < 44; a++) rd(a, 0);
    idle();

    tag = "R6";
    for (int a = 40; a < 44; a++) rd(a, 1);
    rd(7, 1);

    tag = "R9";
    rd(12, 0);
    rd(12, 1);
    rd(12, 0);
    idle();
    idle();

    finish_run();
  end
endmodule